// File: doc/BRIEF.md
# Serial-to-Parallel Word Demultiplexer with Divided Clocks

This block turns a one-bit serial stream, delivered with its bit-rate clock, into parallel words of `WORD_W` bits (16 by default). Every incoming bit is sampled on the falling edge of the bit clock. A free-running phase counter marks off groups of `WORD_W` consecutive bits. When a group is complete, the whole word is moved into an output register at once. The earliest bit of the group lands on output bit 0.

Two divided clocks come out alongside the word. The word clock runs at the bit rate divided by `WORD_W` with an even duty cycle. A second clock is made by halving the word clock, so it runs at the bit rate divided by `2*WORD_W`. The output word and the half-rate clock both change only on the bit-clock edge where the word clock falls. A downstream stage can therefore capture the word on the next rising edge of the word clock, in the middle of a stable window.

The block does no framing or realignment. Word boundaries are set only by where the counter stands since reset. All state is clocked on the falling edge of `bit_clk`. The asynchronous active-low reset is expected to be released in step with that clock.

Top module: `serial_word_demux`

## Requirements
- R1: Each run of `WORD_W` consecutive serial bits, counted from reset, appears as one parallel word on `par_word`.
- R2: `ser_in` is sampled only at the falling edge of `bit_clk`. Its value between a falling edge and the next rising edge has no effect on `par_word`.
- R3: Within a group, the first bit received appears on `par_word[0]` and the last on `par_word[WORD_W-1]`.
- R4: `word_clk` has a period of `WORD_W` bit periods. It is low for the first `WORD_W/2` bit periods after each wrap and high for the remaining `WORD_W/2`.
- R5: `half_clk` toggles once on every falling transition of `word_clk`, giving a period of `2*WORD_W` bit periods.
- R6: `par_word` changes only on the bit-clock edge at which `word_clk` falls, and it holds its value for the rest of that word period.
- R7: `half_clk` changes only on the bit-clock edge at which `word_clk` falls.
- R8: Word boundaries follow the free-running count only. After a reset in the middle of a word, the next word is made of the first `WORD_W` bits sampled after the reset.
- R9: While `rst_n` is low, `par_word`, `word_clk` and `half_clk` are all 0, and the bit counter and shift register are cleared.
- R10: After reset, `par_word` stays 0 for the first `WORD_W-1` falling edges. The first complete word is loaded on the `WORD_W`-th falling edge, when the counter wraps from `WORD_W-1` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Bit-rate clock; all state changes on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with `bit_clk` |
| ser_in | input | 1 | Serial data bit, sampled at the falling edge of `bit_clk` |
| par_word | output | WORD_W | Registered parallel word; bit 0 holds the earliest bit of the group |
| word_clk | output | 1 | Divided clock at bit rate / `WORD_W`, 50% duty |
| half_clk | output | 1 | Divided clock at bit rate / (2*`WORD_W`), toggles on each `word_clk` fall |

## Verification
The bench builds the block with the default `WORD_W` of 16. At that width a word period is short, so a run of a few hundred bit periods covers several dozen wraps and both phases of `half_clk`. The bench checks every bit period, which puts each edge of the counter in reach, including the cycle just before the first wrap after reset. Directed words with a single bit set at either end pin down the bit order. A phase that flips `ser_in` right after each falling edge separates falling-edge sampling from rising-edge sampling. A reset issued in the middle of a word shows that the boundaries restart from the counter.

// File: rtl/demux_pkg.sv
package demux_pkg;

  // Pair of divided clocks produced next to the parallel word.
  typedef struct packed {
    logic word_clk;
    logic half_clk;
  } dmx_clocks_t;

endpackage

// File: rtl/dmx_phase_counter.sv
// Free-running bit position counter; produces the wrap strobe and a
// registered 50%-duty word clock taken from the next counter value.
module dmx_phase_counter #(
  parameter int WORD_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic wrap,
  output logic word_clk
);

  localparam int CNT_W = $clog2(WORD_W);
  localparam int HALF  = WORD_W / 2;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             wclk_q;
  logic             wclk_d;

  always_comb begin
    wrap   = (cnt_q == CNT_W'(WORD_W - 1));
    cnt_d  = wrap ? '0 : cnt_q + 1'b1;
    wclk_d = (cnt_d >= CNT_W'(HALF));
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      wclk_q <= wclk_d;
    end
  end

  assign word_clk = wclk_q;

endmodule

// File: rtl/dmx_shift_capture.sv
// Collects the first WORD_W-1 bits of a group, earliest bit ending at
// index 0; the assembled output appends the bit present this edge.
module dmx_shift_capture #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_in,
  output logic [WORD_W-1:0] assembled
);

  logic [WORD_W-2:0] sh_q;
  logic [WORD_W-2:0] sh_d;

  generate
    if (WORD_W == 2) begin : g_single
      always_comb sh_d = ser_in;
    end else begin : g_multi
      always_comb sh_d = {ser_in, sh_q[WORD_W-2:1]};
    end
  endgenerate

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign assembled = {ser_in, sh_q};

endmodule

// File: rtl/dmx_word_reg.sv
// Output holding register with an explicit load enable.
module dmx_word_reg #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [WORD_W-1:0] d,
  output logic [WORD_W-1:0] q
);

  logic [WORD_W-1:0] q_r;
  logic [WORD_W-1:0] q_d;

  always_comb begin
    q_d = load_en ? d : q_r;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else begin
      q_r <= q_d;
    end
  end

  assign q = q_r;

endmodule

// File: rtl/dmx_half_toggle.sv
// Divide-by-two stage advanced only when its enable is high.
module dmx_half_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic q
);

  logic t_q;
  logic t_d;

  always_comb begin
    t_d = en ? ~t_q : t_q;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q <= 1'b0;
    end else begin
      t_q <= t_d;
    end
  end

  assign q = t_q;

endmodule

// File: rtl/serial_word_demux.sv
// Serial-to-parallel demultiplexer with divide-by-WORD_W and
// divide-by-2*WORD_W clocks. WORD_W must be a power of two, >= 2.
module serial_word_demux #(
  parameter int WORD_W = 16
) (
  input  logic              bit_clk,
  input  logic              rst_n,
  input  logic              ser_in,
  output logic [WORD_W-1:0] par_word,
  output logic              word_clk,
  output logic              half_clk
);

  import demux_pkg::*;

  logic              wrap;
  logic [WORD_W-1:0] assembled;
  dmx_clocks_t       clks;

  dmx_phase_counter #(.WORD_W(WORD_W)) u_phase (
    .clk      (bit_clk),
    .rst_n    (rst_n),
    .wrap     (wrap),
    .word_clk (clks.word_clk)
  );

  dmx_shift_capture #(.WORD_W(WORD_W)) u_shift (
    .clk       (bit_clk),
    .rst_n     (rst_n),
    .ser_in    (ser_in),
    .assembled (assembled)
  );

  // Loads on the same edge where the word clock falls.
  dmx_word_reg #(.WORD_W(WORD_W)) u_out (
    .clk     (bit_clk),
    .rst_n   (rst_n),
    .load_en (wrap),
    .d       (assembled),
    .q       (par_word)
  );

  dmx_half_toggle u_half (
    .clk   (bit_clk),
    .rst_n (rst_n),
    .en    (wrap),
    .q     (clks.half_clk)
  );

  assign word_clk = clks.word_clk;
  assign half_clk = clks.half_clk;

endmodule

// File: rtl/serial_word_demux_checker.sv
module serial_word_demux_checker #(
  parameter int WORD_W = 16
) (
  input logic              bit_clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] par_word,
  input logic              word_clk,
  input logic              half_clk
);

  localparam int HALF  = WORD_W / 2;
  localparam int RUN_W = $clog2(WORD_W) + 1;

  // Bit periods since word_clk last changed (saturating).
  logic [RUN_W-1:0] since;
  logic             wclk_prev;

  always_ff @(negedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      since     <= '0;
      wclk_prev <= 1'b0;
    end else begin
      wclk_prev <= word_clk;
      if (word_clk != wclk_prev) begin
        since <= RUN_W'(1);
      end else if (since < RUN_W'(WORD_W)) begin
        since <= since + 1'b1;
      end
    end
  end

  // R4: each level of word_clk lasts exactly HALF bit periods.
  assert_level_len_R4: assert property (@(negedge bit_clk) disable iff (!rst_n)
    (word_clk != wclk_prev) |-> (since == RUN_W'(HALF)));

  // R4: word_clk never holds a level longer than HALF bit periods.
  assert_level_max_R4: assert property (@(negedge bit_clk) disable iff (!rst_n)
    since <= RUN_W'(HALF));

  // R5: every fall of word_clk flips half_clk.
  assert_half_toggles_R5: assert property (@(negedge bit_clk) disable iff (!rst_n)
    $fell(word_clk) |-> !$stable(half_clk));

  // R6: the output word moves only together with a word_clk fall.
  assert_word_timing_R6: assert property (@(negedge bit_clk) disable iff (!rst_n)
    !$stable(par_word) |-> $fell(word_clk));

  // R7: half_clk moves only together with a word_clk fall.
  assert_half_timing_R7: assert property (@(negedge bit_clk) disable iff (!rst_n)
    !$stable(half_clk) |-> $fell(word_clk));

endmodule

bind serial_word_demux serial_word_demux_checker #(.WORD_W(WORD_W)) u_chk (
  .bit_clk  (bit_clk),
  .rst_n    (rst_n),
  .par_word (par_word),
  .word_clk (word_clk),
  .half_clk (half_clk)
);

// File: tb/serial_word_demux_test.sv
`timescale 1ns/1ps
module serial_word_demux_test;

  localparam int W     = 16;
  localparam int NBITS = 2048;

  logic         bit_clk;
  logic         rst_n;
  logic         ser_in;
  logic [W-1:0] par_word;
  logic         word_clk;
  logic         half_clk;

  int  n_checks;
  int  n_fail;
  bit  finished;
  logic bits [0:NBITS-1];

  serial_word_demux #(.WORD_W(W)) uut (
    .bit_clk  (bit_clk),
    .rst_n    (rst_n),
    .ser_in   (ser_in),
    .par_word (par_word),
    .word_clk (word_clk),
    .half_clk (half_clk)
  );

  initial bit_clk = 1'b0;
  always #2.5 bit_clk = ~bit_clk;

  task automatic cmp(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  function automatic logic [W-1:0] group_word(input int g);
    logic [W-1:0] w;
    for (int i = 0; i < W; i++) w[i] = bits[g*W + i];
    return w;
  endfunction

  // Expected outputs after k falling edges since reset release.
  task automatic check_state(input int k, input string wrap_tag);
    logic [W-1:0] ew;
    int ph;
    ph = k % W;
    ew = (k < W) ? '0 : group_word(k / W - 1);
    if (k < W)        cmp("R10", par_word, ew);
    else if (ph == 0) cmp(wrap_tag, par_word, ew);
    else              cmp("R6", par_word, ew);
    cmp("R4", W'(word_clk), W'(ph >= W/2));
    if (ph == 0) cmp("R5", W'(half_clk), W'((k / W) % 2));
    else         cmp("R7", W'(half_clk), W'((k / W) % 2));
  endtask

  // Runs n bit periods starting at count k; optional glitch after sampling.
  task automatic run_bits(inout int k, input int n, input bit glitch, input bit phase_b);
    string tag;
    for (int i = 0; i < n; i++) begin
      if (phase_b) tag = (k == W) ? "R8" : "R2";
      else         tag = (k / W <= 6) ? "R3" : "R1";
      check_state(k, tag);
      ser_in = bits[k];
      @(negedge bit_clk);
      #1;
      if (glitch) ser_in = ~ser_in;
      k++;
      @(posedge bit_clk);
      #1;
    end
  endtask

  task automatic set_group(input int g, input logic [W-1:0] v);
    for (int i = 0; i < W; i++) bits[g*W + i] = v[i];
  endtask

  initial begin
    int k;
    void'($urandom(32'h0000_51C7));
    n_checks = 0;
    n_fail   = 0;
    finished = 0;
    rst_n    = 1'b0;
    ser_in   = 1'b0;

    // R9: outputs held at zero during reset, even with input toggling.
    for (int i = 0; i < 4; i++) begin
      @(posedge bit_clk);
      #1;
      ser_in = ~ser_in;
      cmp("R9", par_word, '0);
      cmp("R9", W'(word_clk), '0);
      cmp("R9", W'(half_clk), '0);
    end

    // Phase A: directed groups then random groups.
    for (int i = 0; i < NBITS; i++) bits[i] = 1'($urandom);
    set_group(0, 16'hFFFF);
    set_group(1, 16'h0001);   // R3: first bit only -> bit 0
    set_group(2, 16'h8000);   // R3: last bit only -> bit 15
    set_group(3, 16'h1234);
    set_group(4, 16'h0000);
    set_group(5, 16'hFFFE);
    rst_n = 1'b1;
    k = 0;
    run_bits(k, 40*W + 7, 1'b0, 1'b0);

    // R8/R9: reset in the middle of a word.
    rst_n = 1'b0;
    #1;
    cmp("R9", par_word, '0);
    cmp("R9", W'(word_clk), '0);
    cmp("R9", W'(half_clk), '0);
    @(posedge bit_clk);
    #1;
    for (int i = 0; i < NBITS; i++) bits[i] = 1'($urandom);
    set_group(1, 16'hA5C3);
    rst_n = 1'b1;
    k = 0;

    // Phase B: input flipped after each sampling edge (R2).
    run_bits(k, 24*W + 1, 1'b1, 1'b1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(50000 * 5);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule